// File: doc/BRIEF.md
# DMA Channel Status and Fault Monitor

This block sits next to one DMA channel and keeps the sticky status word that software polls or is interrupted on. Each time the channel presents a source or destination pointer, the block checks it against a programmable address window and against the alignment that the current transfer size needs. When a check fails, the block latches a two-bit fault code. It also latches bus read and write errors, the end of the transfer count, the halfway point of that count, triggers that arrive while the previous operation is still running, and pattern-match events.

The block keeps the transfer counter itself. `ch_start` loads a starting count, and each completed transfer (`ack`) takes one off it. Software reads the status word through a combinational read port and clears flags by writing ones to them. The buffered-write bit is not a stored flag: it reflects a level from the datapath and is read-only.

Top module: `dma_stat_mon`

## Requirements
- R1: When `acc_valid` is high, the fault code in status bits 7:6 is computed with this priority: 2'b11 for a misaligned pointer; otherwise 2'b10 if the address is greater than `lim_hi`; otherwise 2'b01 if the address is below `lim_lo` and greater than parameter `SFR_TOP`; otherwise 2'b00. An address at or below `SFR_TOP` never gives 2'b01.
- R2: The `acc_size` encoding is 0 for byte, 1 for halfword, 2 for word, and 3 is treated as word. A byte is always aligned. A halfword needs address bit 0 clear. A word needs address bits 1:0 clear.
- R3: A nonzero fault code holds its first recorded value until software clears it, even when later faults of any kind arrive.
- R4: A pulse on `bus_rd_err` sets status bit 8 and a pulse on `bus_wr_err` sets status bit 9. Both bits are sticky.
- R5: Status bit 5 sets in the cycle after an `ack` takes the remaining count from 1 to 0. An `ack` when the count is already 0 does nothing.
- R6: Status bit 4 sets in the cycle after the first `ack` that leaves the remaining count at or below the start count shifted right by one bit.
- R7: Status bit 3 sets when `trig` arrives while an operation is still running and `ack` is not high in that same cycle. An operation runs from `trig` until `ack`.
- R8: A pulse on `match_evt` sets status bit 1.
- R9: Status bit 0 always equals `buf_pend`. Writes have no effect on it.
- R10: A write with `wr_en` high clears each sticky bit whose `wr_data` bit is 1. A write of 1 to bit 6 or bit 7 clears the fault code. Bits written as 0 keep their value. If a hardware set and a software clear hit the same bit in the same cycle, the set wins.
- R11: After reset the whole status word is 0. Bits 15:10 and bit 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Pointer presented for checking |
| acc_addr | input | AW | Pointer address |
| acc_size | input | 2 | Transfer size code |
| lim_lo | input | AW | Lower bound of the permitted window |
| lim_hi | input | AW | Upper bound of the permitted window |
| bus_rd_err | input | 1 | Bus read error pulse |
| bus_wr_err | input | 1 | Bus write error pulse |
| ch_start | input | 1 | Load the starting transfer count |
| start_cnt | input | CW | Starting transfer count |
| trig | input | 1 | Transfer trigger |
| ack | input | 1 | Transfer completed |
| match_evt | input | 1 | Pattern match detected |
| buf_pend | input | 1 | Buffered data not yet written |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Write-one-to-clear mask |
| rd_data | output | 16 | Status word |

## Verification
The bench sweeps addresses across every edge of the window, on both sides of `lim_lo`, `lim_hi` and `SFR_TOP`, in all four size codes. An error in priority or in a boundary comparison would show as a wrong code at exactly those edges, for example 2'b10 reported for a misaligned pointer above the window, or 2'b01 reported for a special-register address. Start counts from 1 to 12 cover odd counts, where the halfway test is off by one if the threshold is rounded the wrong way, and a count of 1, where HALF and DONE must rise together. The bench also forces a same-cycle set and clear, faults arriving in both orders, and a trigger that lands together with `ack`. A design that lets the clear win, overwrites the first fault, or reports a false overrun would fail those checks.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  localparam int unsigned ST_W = 16;

  // status bit positions
  localparam int unsigned B_BUF   = 0;
  localparam int unsigned B_MATCH = 1;
  localparam int unsigned B_OVR   = 3;
  localparam int unsigned B_HALF  = 4;
  localparam int unsigned B_DONE  = 5;
  localparam int unsigned B_FLT_L = 6;
  localparam int unsigned B_FLT_H = 7;
  localparam int unsigned B_BRERR = 8;
  localparam int unsigned B_BWERR = 9;

  // sticky single-bit flags, index into a vector
  localparam int unsigned F_MATCH = 0;
  localparam int unsigned F_OVR   = 1;
  localparam int unsigned F_HALF  = 2;
  localparam int unsigned F_DONE  = 3;
  localparam int unsigned F_BRERR = 4;
  localparam int unsigned F_BWERR = 5;
  localparam int unsigned NFLAG   = 6;

  localparam logic [1:0] FC_NONE  = 2'b00;
  localparam logic [1:0] FC_LOW   = 2'b01;
  localparam logic [1:0] FC_HIGH  = 2'b10;
  localparam logic [1:0] FC_ALIGN = 2'b11;

  // low address bits that must be zero for a given size
  function automatic logic [1:0] align_mask(xfer_size_e sz);
    case (sz)
      SZ_BYTE: align_mask = 2'b00;
      SZ_HALF: align_mask = 2'b01;
      default: align_mask = 2'b11;
    endcase
  endfunction

  function automatic logic is_misaligned(logic [1:0] lsb, xfer_size_e sz);
    is_misaligned = |(lsb & align_mask(sz));
  endfunction

  // map a flag index to its status bit position
  function automatic int unsigned flag_pos(int unsigned idx);
    case (idx)
      F_MATCH: flag_pos = B_MATCH;
      F_OVR:   flag_pos = B_OVR;
      F_HALF:  flag_pos = B_HALF;
      F_DONE:  flag_pos = B_DONE;
      F_BRERR: flag_pos = B_BRERR;
      default: flag_pos = B_BWERR;
    endcase
  endfunction

endpackage

// File: rtl/dsm_addr_chk.sv
module dsm_addr_chk
  import dsm_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter logic [AW-1:0] SFR_TOP = '0
) (
  input  logic          chk_valid,
  input  logic [AW-1:0] addr,
  input  xfer_size_e    size,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [1:0]    code
);

  logic mis, above, below;

  always_comb begin
    mis   = is_misaligned(addr[1:0], size);
    above = addr > hi;
    below = (addr < lo) && (addr > SFR_TOP);
    code  = FC_NONE;
    if (chk_valid) begin
      if (mis)        code = FC_ALIGN;
      else if (above) code = FC_HIGH;
      else if (below) code = FC_LOW;
    end
  end

endmodule

// File: rtl/dsm_progress.sv
module dsm_progress #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_start,
  input  logic [CW-1:0] start_cnt,
  input  logic          trig,
  input  logic          ack,
  output logic          done_evt,
  output logic          half_evt,
  output logic          ovr_evt,
  output logic          busy
);

  logic [CW-1:0] rem_q, half_q, rem_nx;
  logic          armed_q, dec;

  assign dec      = ack && (rem_q != '0);
  assign rem_nx   = rem_q - 1'b1;
  assign done_evt = dec && (rem_q == {{(CW-1){1'b0}}, 1'b1});
  assign half_evt = dec && armed_q && (rem_nx <= half_q);
  assign ovr_evt  = trig && busy && !ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      half_q  <= '0;
      armed_q <= 1'b0;
    end else if (ch_start) begin
      rem_q   <= start_cnt;
      half_q  <= start_cnt >> 1;
      armed_q <= start_cnt != '0;
    end else if (dec) begin
      rem_q <= rem_nx;
      if (half_evt) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy <= 1'b0;
    else if (trig) busy <= 1'b1;
    else if (ack)  busy <= 1'b0;
  end

endmodule

// File: rtl/dsm_flags.sv
module dsm_flags #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (set_vec[i]) q[i] <= 1'b1;
      else if (clr_vec[i]) q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/dsm_fault_reg.sv
module dsm_fault_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] new_code,
  input  logic       clr,
  output logic [1:0] code_q
);

  logic take;
  assign take = (new_code != 2'b00) && ((code_q == 2'b00) || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= 2'b00;
    else if (take) code_q <= new_code;
    else if (clr)  code_q <= 2'b00;
  end

endmodule

// File: rtl/dma_stat_mon.sv
module dma_stat_mon
  import dsm_pkg::*;
#(
  parameter int unsigned   AW      = 16,
  parameter int unsigned   CW      = 8,
  parameter logic [AW-1:0] SFR_TOP = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] lim_lo,
  input  logic [AW-1:0] lim_hi,
  input  logic          bus_rd_err,
  input  logic          bus_wr_err,
  input  logic          ch_start,
  input  logic [CW-1:0] start_cnt,
  input  logic          trig,
  input  logic          ack,
  input  logic          match_evt,
  input  logic          buf_pend,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data
);

  logic [1:0]       new_code, fault_q;
  logic             done_evt, half_evt, ovr_evt, busy, fault_clr;
  logic [NFLAG-1:0] set_vec, clr_vec, flag_q;
  logic             unused_wr_bits;

  dsm_addr_chk #(.AW(AW), .SFR_TOP(SFR_TOP)) u_chk (
    .chk_valid (acc_valid),
    .addr      (acc_addr),
    .size      (xfer_size_e'(acc_size)),
    .lo        (lim_lo),
    .hi        (lim_hi),
    .code      (new_code)
  );

  dsm_progress #(.CW(CW)) u_prog (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_start  (ch_start),
    .start_cnt (start_cnt),
    .trig      (trig),
    .ack       (ack),
    .done_evt  (done_evt),
    .half_evt  (half_evt),
    .ovr_evt   (ovr_evt),
    .busy      (busy)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[F_MATCH] = match_evt;
    set_vec[F_OVR]   = ovr_evt;
    set_vec[F_HALF]  = half_evt;
    set_vec[F_DONE]  = done_evt;
    set_vec[F_BRERR] = bus_rd_err;
    set_vec[F_BWERR] = bus_wr_err;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_clr
    assign clr_vec[i] = wr_en && wr_data[flag_pos(i)];
  end

  assign fault_clr = wr_en && (wr_data[B_FLT_H] || wr_data[B_FLT_L]);
  assign unused_wr_bits = ^{wr_data[15:10], wr_data[2], wr_data[0]};

  dsm_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (flag_q)
  );

  dsm_fault_reg u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_code (new_code),
    .clr      (fault_clr),
    .code_q   (fault_q)
  );

  always_comb begin
    rd_data                  = '0;
    rd_data[B_BUF]           = buf_pend;
    rd_data[B_FLT_H:B_FLT_L] = fault_q;
    for (int i = 0; i < NFLAG; i++) rd_data[flag_pos(i)] = flag_q[i];
  end

endmodule

// File: rtl/dsm_sva.sv
module dsm_sva #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic [1:0]    acc_size,
  input logic          trig,
  input logic          ack,
  input logic          match_evt,
  input logic          buf_pend,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic [15:0]   rd_data,
  input logic          busy,
  input logic          done_evt
);

  logic mis_chk;
  assign mis_chk = (acc_size == 2'd1 && acc_addr[0]) ||
                   (acc_size[1] && acc_addr[1:0] != 2'b00);

  // R2: a misaligned pointer seen while no fault is held gives code 11
  a_r2_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && mis_chk && rd_data[7:6] == 2'b00 |=> rd_data[7:6] == 2'b11);

  // R3: a held code does not change unless it is being cleared
  a_r3_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] != 2'b00 && !(wr_en && (wr_data[7] || wr_data[6]))
    |=> rd_data[7:6] == $past(rd_data[7:6]));

  // R5: the terminal count raises DONE
  a_r5_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> rd_data[5]);

  // R7: a trigger that lands on a running operation raises OVERRUN
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy && !ack |=> rd_data[3]);

  // R9: the buffered-write bit follows its input
  a_r9_buf: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] == buf_pend);

  // R10: a clear with no competing set drops MATCH
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[1] && !match_evt |=> !rd_data[1]);

  // R10: a set wins over a clear in the same cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> rd_data[1]);

  // R11: reserved bits read zero
  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:10] == 6'd0 && !rd_data[2]);

endmodule

bind dma_stat_mon dsm_sva #(.AW(AW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .acc_size  (acc_size),
  .trig      (trig),
  .ack       (ack),
  .match_evt (match_evt),
  .buf_pend  (buf_pend),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .busy      (busy),
  .done_evt  (done_evt)
);

// File: tb/tb_dma_stat_mon.sv
module tb_dma_stat_mon;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam logic [AW-1:0] SFR = 16'h0FFF;
  localparam logic [AW-1:0] LO  = 16'h2000;
  localparam logic [AW-1:0] HI  = 16'h2FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_size = 2'd0;
  logic bus_rd_err = 1'b0, bus_wr_err = 1'b0;
  logic ch_start = 1'b0;
  logic [CW-1:0] start_cnt = '0;
  logic trig = 1'b0, ack = 1'b0, match_evt = 1'b0, buf_pend = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_stat_mon #(.AW(AW), .CW(CW), .SFR_TOP(SFR)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .lim_lo(LO), .lim_hi(HI), .bus_rd_err(bus_rd_err),
    .bus_wr_err(bus_wr_err), .ch_start(ch_start), .start_cnt(start_cnt),
    .trig(trig), .ack(ack), .match_evt(match_evt), .buf_pend(buf_pend),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected code worked out arithmetically
  function automatic logic [1:0] exp_code(int a, int sz);
    int bytes = (sz >= 2) ? 4 : (1 << sz);
    if (a % bytes != 0) return 2'b11;
    if (a > int'(HI))   return 2'b10;
    if (a < int'(LO) && a > int'(SFR)) return 2'b01;
    return 2'b00;
  endfunction

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 16'hFFFF;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic access(int a, int sz);
    acc_valid = 1'b1; acc_addr = a[AW-1:0]; acc_size = sz[1:0];
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic pulse_trig(); trig = 1'b1; @(negedge clk); trig = 1'b0; endtask
  task automatic pulse_ack();  ack = 1'b1;  @(negedge clk); ack = 1'b0;  endtask

  task automatic addr_point(int a);
    for (int sz = 0; sz < 4; sz++) begin
      if (a < 0 || a > 16'hFFFF) continue;
      access(a, sz);
      check($sformatf("R1/R2 addr=%h size=%0d", a, sz),
            {14'd0, rd_data[7:6]}, {14'd0, exp_code(a, sz)});
      clear_all();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int edges[6];
    edges = '{int'(SFR), int'(SFR) + 1, int'(LO), int'(HI), int'(HI) + 1, 0};
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset word", rd_data, 16'h0000);

    // R1 R2 sweep across the address space and the window edges
    for (int a = 0; a < 16'h3400; a += 16'h00F3) addr_point(a);
    foreach (edges[e])
      for (int d = -3; d <= 3; d++) addr_point(edges[e] + d);

    // R3: first fault held, both orders
    access(16'h3001, 2); access(16'h3000, 2);
    check("R3 misalign then high", {14'd0, rd_data[7:6]}, 16'd3);
    clear_all();
    access(16'h3000, 2); access(16'h3001, 2); access(16'h1800, 0);
    check("R3 high then others", {14'd0, rd_data[7:6]}, 16'd2);
    // R10: a new fault together with the clear wins
    acc_valid = 1'b1; acc_addr = 16'h1800; acc_size = 2'd0;
    wr_en = 1'b1; wr_data = 16'h0040;
    @(negedge clk);
    acc_valid = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R10 fault set beats clear", {14'd0, rd_data[7:6]}, 16'd1);
    clear_all();
    check("R10 fault cleared", rd_data, 16'h0000);

    // R4 bus errors
    bus_rd_err = 1'b1; @(negedge clk); bus_rd_err = 1'b0;
    check("R4 read error", rd_data, 16'h0100);
    bus_wr_err = 1'b1; @(negedge clk); bus_wr_err = 1'b0;
    check("R4 write error", rd_data, 16'h0300);
    wr_en = 1'b1; wr_data = 16'h0000; @(negedge clk); wr_en = 1'b0;
    check("R10 write zero keeps", rd_data, 16'h0300);
    wr_en = 1'b1; wr_data = 16'h0100; @(negedge clk); wr_en = 1'b0;
    check("R10 clear only bit8", rd_data, 16'h0200);
    clear_all();

    // R5 R6 count sweep
    for (int n = 1; n <= 12; n++) begin
      start_cnt = n[CW-1:0]; ch_start = 1'b1; @(negedge clk); ch_start = 1'b0;
      for (int k = 1; k <= n; k++) begin
        pulse_trig();
        pulse_ack();
        check($sformatf("R6 half n=%0d k=%0d", n, k), {15'd0, rd_data[4]},
              {15'd0, (n - k) <= (n >> 1)});
        check($sformatf("R5 done n=%0d k=%0d", n, k), {15'd0, rd_data[5]},
              {15'd0, k == n});
        check($sformatf("R7 no overrun n=%0d k=%0d", n, k), {15'd0, rd_data[3]}, 16'd0);
      end
      pulse_ack();
      check($sformatf("R5 ack at zero n=%0d", n), rd_data, 16'h0030);
      clear_all();
    end

    // R7 overrun
    pulse_trig();
    trig = 1'b1; ack = 1'b1; @(negedge clk); trig = 1'b0; ack = 1'b0;
    check("R7 trig with ack no overrun", {15'd0, rd_data[3]}, 16'd0);
    pulse_trig();
    check("R7 trig while busy", {15'd0, rd_data[3]}, 16'd1);
    pulse_ack();
    clear_all();

    // R8 match and set-wins
    match_evt = 1'b1; @(negedge clk); match_evt = 1'b0;
    check("R8 match set", rd_data, 16'h0002);
    match_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h0002;
    @(negedge clk); match_evt = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R10 set beats clear", rd_data, 16'h0002);
    clear_all();
    check("R10 match cleared", rd_data, 16'h0000);

    // R9 buffered-write bit
    buf_pend = 1'b1; @(negedge clk);
    check("R9 follows input", rd_data, 16'h0001);
    clear_all();
    check("R9 write has no effect", rd_data, 16'h0001);
    buf_pend = 1'b0; @(negedge clk);
    check("R9 drops with input", rd_data, 16'h0000);

    // R11 reserved bits stay zero after writes of ones
    clear_all();
    check("R11 reserved bits", rd_data & 16'hFC04, 16'h0000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule